// File: doc/BRIEF.md
# Parallel Flash Query and Identifier Responder

This block produces the read data that a bank of identical flash devices returns while it is in query mode or identifier mode. Several devices share one data bus. Each device drives its own byte lanes, and the host sees every device answer in parallel. The responder takes the bus byte address, a read size and a mode select. It turns the address into the per-device table index that each device would decode. It then fetches a query-table byte or an identifier code and widens it to the device width. Finally it copies the device answer into every device lane of the bank.

A read wider than the bank is built from several bank-sized lookups at stepped addresses. Bytes beyond the requested read size are zero. The bank width, the device width and the widest width the device supports are parameters. So are the identifier codes and the erase geometry, and the table is computed from that geometry. The result is registered, so data appears one clock after the read strobe, like an array read.

Top module: `flash_qry_responder`

## Requirements
- R1: While reset is low at a clock edge, `rsp_valid` and `rsp_data` become zero.
- R2: A read strobe on `rd_en` gives `rsp_valid` high on the next clock only. `rsp_data` then holds its value until the next strobe.
- R3: The table index is the byte address shifted right by log2(bank bytes) + log2(max device bytes) − log2(device bytes). Address bits below that shift do not affect the result. In query mode (`rd_mode` = 0), indices 0x10..0x12 return the ASCII bytes "QRY" and indices 0x31..0x33 return "PRI".
- R4: In query mode, an index at or beyond the table length (82) returns zero. The whole index is compared, not only its low byte.
- R5: When the device width is below the maximum device width, the query byte fills every byte of the device answer instead of being zero padded. This holds only for a 1-byte device width on a bank of at most 4 bytes; any other narrowed configuration answers zero.
- R6: The device answer is copied into every device-width lane of the bank word.
- R7: In identifier mode (`rd_mode` = 1), only the low 8 bits of the index are decoded. Value 0 returns the manufacturer code and value 1 returns the device code, each truncated or zero-extended to the device width. Every other value returns zero.
- R8: For a read wider than the bank, bank lane k (bytes k·B..k·B+B−1, B = bank bytes) comes from a lookup at byte address addr + k·B·B.
- R9: `rd_size` gives log2 of the read size in bytes. Result bytes at or above that size are zero.
- R10: Query index 0x27 holds log2 of the per-device size. Index 0x2C holds 1, one uniform erase region. Indices 0x2D/0x2E hold the block count minus one, low byte first. Indices 0x2F/0x30 hold bits 15:8 and 23:16 of the per-device block size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_mode | input | 1 | 0 = query table, 1 = identifier codes |
| rd_addr | input | ADDR_W | Bus byte address |
| rd_size | input | SIZE_W | log2 of read size in bytes |
| rsp_valid | output | 1 | Result valid, one clock after the strobe |
| rsp_data | output | 8·BUS_BYTES | Assembled read result |

## Verification
The assertions assume a read strobe lasts one cycle per read and that `rd_size` is at most log2 of the bus width. They also assume the widths are powers of two with the device width no larger than the bank. The lane-equality property applies only when the device width is one byte. The stimulus issues each read as a single-cycle strobe with sizes 0 to 2 on the 4-byte default bus, using the default 2-byte bank of 1-byte devices narrowed from 2-byte parts. Idle gaps between reads let the hold property be observed.

// File: rtl/flash_qry_pkg.sv
// Shared types and the query table contents.
// Assumes the table is addressed by an 8-bit index already range-checked.
package flash_qry_pkg;

    typedef enum logic {
        MODE_QUERY = 1'b0,
        MODE_IDENT = 1'b1
    } rsp_mode_e;

    localparam int unsigned QRY_TABLE_LEN = 82;

    // One query-table byte, computed from the geometry arguments.
    function automatic logic [7:0] qry_table_byte(
        input logic [7:0]  idx,
        input logic [7:0]  size_lg,
        input logic [15:0] blocks_m1,
        input logic [31:0] dev_blk_bytes,
        input logic [7:0]  wbuf_lg
    );
        logic [7:0] b;
        case (idx)
            8'h10: b = 8'h51;                // 'Q'
            8'h11: b = 8'h52;                // 'R'
            8'h12: b = 8'h59;                // 'Y'
            8'h13: b = 8'h01;
            8'h15: b = 8'h31;
            8'h1B: b = 8'h45;
            8'h1C: b = 8'h55;
            8'h1F: b = 8'h07;
            8'h20: b = 8'h07;
            8'h21: b = 8'h0A;
            8'h23: b = 8'h04;
            8'h24: b = 8'h04;
            8'h25: b = 8'h04;
            8'h27: b = size_lg;
            8'h28: b = 8'h02;
            8'h2A: b = wbuf_lg;
            8'h2C: b = 8'h01;
            8'h2D: b = blocks_m1[7:0];
            8'h2E: b = blocks_m1[15:8];
            8'h2F: b = dev_blk_bytes[15:8];
            8'h30: b = dev_blk_bytes[23:16];
            8'h31: b = 8'h50;                // 'P'
            8'h32: b = 8'h52;                // 'R'
            8'h33: b = 8'h49;                // 'I'
            8'h34: b = 8'h31;                // '1'
            8'h35: b = 8'h30;                // '0'
            8'h3F: b = 8'h01;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/flash_qry_index.sv
// Address scaler: turns a bus byte address into the index a single
// device decodes. Assumes all widths are powers of two, so SHIFT is
// log2(bank) + log2(max device) - log2(device).
module flash_qry_index #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned SHIFT  = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] idx
);

    // Drop the byte-lane and device-width address bits.
    always_comb begin
        idx = addr >> SHIFT;
    end

endmodule

// File: rtl/flash_qry_lane.sv
// One bank-wide lookup: fetches a query byte or identifier code for the
// given index, widens it to one device, then copies it to each device
// lane of the bank. Assumes DEV_BYTES divides BANK_BYTES.
module flash_qry_lane
    import flash_qry_pkg::*;
#(
    parameter int unsigned ADDR_W        = 16,
    parameter int unsigned BANK_BYTES    = 2,
    parameter int unsigned DEV_BYTES     = 1,
    parameter int unsigned MAXDEV_BYTES  = 2,
    parameter logic [15:0] MFR_CODE      = 16'h0089,
    parameter logic [15:0] DEV_CODE      = 16'h0018,
    parameter logic [7:0]  SIZE_LG       = 8'd22,
    parameter logic [15:0] BLOCKS_M1     = 16'd63,
    parameter logic [31:0] DEV_BLK_BYTES = 32'd65536,
    parameter logic [7:0]  WBUF_LG       = 8'h0B
) (
    input  rsp_mode_e             mode,
    input  logic [ADDR_W-1:0]     idx,
    output logic [8*BANK_BYTES-1:0] bank_word
);

    localparam int unsigned NDEV   = BANK_BYTES / DEV_BYTES;
    localparam int unsigned DW     = 8 * DEV_BYTES;
    localparam bit          NARROW = DEV_BYTES < MAXDEV_BYTES;
    localparam bit          X8_OK  = (DEV_BYTES == 1) && (BANK_BYTES <= 4);

    logic [7:0]  qbyte;
    logic [DW-1:0] qry_word;
    logic [DW-1:0] id_word;
    logic [DW-1:0] dev_word;
    logic [63:0] id_ext;

    // Fetch the table byte; out-of-range indices read as zero.
    always_comb begin
        if (idx < ADDR_W'(QRY_TABLE_LEN)) begin
            qbyte = qry_table_byte(idx[7:0], SIZE_LG, BLOCKS_M1,
                                   DEV_BLK_BYTES, WBUF_LG);
        end else begin
            qbyte = 8'h00;
        end
    end

    // Widen the query byte to one device according to the width mode.
    generate
        if (NARROW && X8_OK) begin : g_x8_repeat
            always_comb qry_word = {DEV_BYTES{qbyte}};
        end else if (NARROW) begin : g_x8_unsup
            always_comb qry_word = '0;
        end else begin : g_native
            always_comb qry_word = DW'(qbyte);
        end
    endgenerate

    // Decode the identifier index on its low byte only.
    always_comb begin
        case (idx[7:0])
            8'h00:   id_ext = 64'(MFR_CODE);
            8'h01:   id_ext = 64'(DEV_CODE);
            default: id_ext = 64'd0;
        endcase
        id_word = id_ext[DW-1:0];
    end

    // Select the device answer for the current mode.
    always_comb begin
        dev_word = (mode == MODE_IDENT) ? id_word : qry_word;
    end

    // Copy the device answer into every device lane of the bank.
    generate
        for (genvar d = 0; d < NDEV; d++) begin : g_dev_lane
            assign bank_word[d*DW +: DW] = dev_word;
        end
    endgenerate

endmodule

// File: rtl/flash_qry_responder.sv
// Query/identifier read responder for a bank of parallel flash devices.
// Splits a bus read into bank-wide lookups, masks bytes above the read
// size and registers the result one clock after the strobe.
// Assumes power-of-two widths, DEV_BYTES <= BANK_BYTES, and a one-cycle
// strobe per read.
module flash_qry_responder
    import flash_qry_pkg::*;
#(
    parameter int unsigned ADDR_W       = 16,
    parameter int unsigned SIZE_W       = 2,
    parameter int unsigned BUS_BYTES    = 4,
    parameter int unsigned BANK_BYTES   = 2,
    parameter int unsigned DEV_BYTES    = 1,
    parameter int unsigned MAXDEV_BYTES = 2,
    parameter int unsigned BLOCK_COUNT  = 64,
    parameter int unsigned BLOCK_BYTES  = 131072,
    parameter logic [15:0] MFR_CODE     = 16'h0089,
    parameter logic [15:0] DEV_CODE     = 16'h0018
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_en,
    input  logic                   rd_mode,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [SIZE_W-1:0]      rd_size,
    output logic                   rsp_valid,
    output logic [8*BUS_BYTES-1:0] rsp_data
);

    localparam int unsigned NDEV      = BANK_BYTES / DEV_BYTES;
    localparam int unsigned SHIFT     = $clog2(BANK_BYTES) + $clog2(MAXDEV_BYTES)
                                        - $clog2(DEV_BYTES);
    localparam int unsigned LOOKS     = (BUS_BYTES > BANK_BYTES) ?
                                        BUS_BYTES / BANK_BYTES : 1;
    localparam int unsigned ASM_BYTES = LOOKS * BANK_BYTES;
    localparam int unsigned DEV_BLK   = BLOCK_BYTES / NDEV;
    localparam logic [7:0]  SIZE_LG   = 8'($clog2(BLOCK_COUNT) + $clog2(DEV_BLK));
    localparam logic [15:0] BLOCKS_M1 = 16'(BLOCK_COUNT - 1);
    localparam logic [7:0]  WBUF_LG   = (BANK_BYTES == 1) ? 8'h08 : 8'h0B;

    logic [8*ASM_BYTES-1:0] assembled;
    logic [BUS_BYTES-1:0]   keep;
    logic [8*BUS_BYTES-1:0] masked;
    rsp_mode_e              mode;

    assign mode = rsp_mode_e'(rd_mode);

    // One scaler and one lookup per bank lane of the bus word.
    generate
        for (genvar k = 0; k < LOOKS; k++) begin : g_look
            logic [ADDR_W-1:0] look_addr;
            logic [ADDR_W-1:0] look_idx;

            assign look_addr = rd_addr + ADDR_W'(k * BANK_BYTES * BANK_BYTES);

            flash_qry_index #(
                .ADDR_W (ADDR_W),
                .SHIFT  (SHIFT)
            ) u_index (
                .addr (look_addr),
                .idx  (look_idx)
            );

            flash_qry_lane #(
                .ADDR_W        (ADDR_W),
                .BANK_BYTES    (BANK_BYTES),
                .DEV_BYTES     (DEV_BYTES),
                .MAXDEV_BYTES  (MAXDEV_BYTES),
                .MFR_CODE      (MFR_CODE),
                .DEV_CODE      (DEV_CODE),
                .SIZE_LG       (SIZE_LG),
                .BLOCKS_M1     (BLOCKS_M1),
                .DEV_BLK_BYTES (32'(DEV_BLK)),
                .WBUF_LG       (WBUF_LG)
            ) u_lane (
                .mode      (mode),
                .idx       (look_idx),
                .bank_word (assembled[k*8*BANK_BYTES +: 8*BANK_BYTES])
            );
        end
    endgenerate

    // Zero every byte at or above the requested read size.
    always_comb begin
        for (int j = 0; j < BUS_BYTES; j++) begin
            keep[j] = (32'(j) < (32'd1 << rd_size));
            masked[8*j +: 8] = keep[j] ? assembled[8*j +: 8] : 8'h00;
        end
    end

    // Output stage: one clock of latency, data held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en) begin
                rsp_data <= masked;
            end
        end
    end

endmodule

// File: rtl/flash_qry_chk.sv
// Port-level checker for the responder, attached by bind below.
// Assumes one-cycle strobes and read sizes within the bus width.
module flash_qry_chk #(
    parameter int unsigned SIZE_W     = 2,
    parameter int unsigned BUS_BYTES  = 4,
    parameter int unsigned BANK_BYTES = 2,
    parameter int unsigned DEV_BYTES  = 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   rd_en,
    input logic [SIZE_W-1:0]      rd_size,
    input logic                   rsp_valid,
    input logic [8*BUS_BYTES-1:0] rsp_data
);

    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rsp_valid);                                          // R2

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rsp_valid);                                        // R2

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rsp_data));                                 // R2

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && rsp_data == '0));                    // R1

    AST_SINGLE_BYTE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_size == '0) |=> (rsp_data[8*BUS_BYTES-1:8] == '0)); // R9

    generate
        if (DEV_BYTES == 1 && BANK_BYTES >= 2 && BUS_BYTES >= 2) begin : g_lane_eq
            AST_LANES_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && rd_size != '0) |=> (rsp_data[15:8] == rsp_data[7:0])); // R6
        end
    endgenerate

endmodule

bind flash_qry_responder flash_qry_chk #(
    .SIZE_W     (SIZE_W),
    .BUS_BYTES  (BUS_BYTES),
    .BANK_BYTES (BANK_BYTES),
    .DEV_BYTES  (DEV_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_size   (rd_size),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
);

// File: tb/tb_flash_qry_responder.sv
// Bench for the default configuration: 4-byte bus, 2-byte bank of
// 1-byte devices narrowed from 2-byte parts (index = addr >> 2).
module tb_flash_qry_responder;

    logic        clk;
    logic        rst_n;
    logic        rd_en;
    logic        rd_mode;
    logic [15:0] rd_addr;
    logic [1:0]  rd_size;
    logic        rsp_valid;
    logic [31:0] rsp_data;

    int total;
    int bad;
    int cycles;

    flash_qry_responder dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .rd_mode   (rd_mode),
        .rd_addr   (rd_addr),
        .rd_size   (rd_size),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    typedef struct packed {
        logic        mode;
        logic [15:0] addr;
        logic [1:0]  size;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [0:NVEC-1] = '{
        '{1'b0, 16'h0040, 2'd2, 32'h52525151},  // R3 R8 "Q","R"
        '{1'b0, 16'h0048, 2'd2, 32'h01015959},  // R3 R8 "Y", 0x13
        '{1'b0, 16'h0040, 2'd0, 32'h00000051},  // R9 one byte
        '{1'b0, 16'h0040, 2'd1, 32'h00005151},  // R5 R6 R9 repeat, two bytes
        '{1'b0, 16'h00C4, 2'd2, 32'h52525050},  // R3 "P","R"
        '{1'b0, 16'h00CC, 2'd1, 32'h00004949},  // R3 "I"
        '{1'b0, 16'h009C, 2'd2, 32'h02021616},  // R10 size log2 = 22
        '{1'b0, 16'h00B0, 2'd2, 32'h3F3F0101},  // R10 one region, blocks-1
        '{1'b0, 16'h00C0, 2'd2, 32'h50500101},  // R10 block size bits 23:16
        '{1'b0, 16'h0440, 2'd2, 32'h00000000},  // R4 index 0x110 beyond table
        '{1'b0, 16'h0043, 2'd2, 32'h52525151},  // R3 low address bits ignored
        '{1'b1, 16'h0000, 2'd2, 32'h18188989},  // R7 R8 manufacturer, device
        '{1'b1, 16'h0008, 2'd2, 32'h00000000},  // R7 indices 2,3 read zero
        '{1'b1, 16'h0400, 2'd1, 32'h00008989},  // R7 only low index byte decoded
        '{1'b1, 16'h0404, 2'd0, 32'h00000018}   // R7 R9 device code, one byte
    };

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle strobe; result sampled at the following falling edge.
    task automatic do_read(input logic mode, input logic [15:0] addr,
                           input logic [1:0] size, output logic [31:0] data,
                           output logic valid);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_mode = mode;
        rd_addr = addr;
        rd_size = size;
        @(negedge clk);
        rd_en = 1'b0;
        data  = rsp_data;
        valid = rsp_valid;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        cycles = 0;
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                bad++;
                total++;
                $display("FAIL R2 watchdog actual=timeout expected=done");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] d;
        logic        v;
        logic [31:0] held;
        total   = 0;
        bad     = 0;
        rst_n   = 1'b0;
        rd_en   = 1'b0;
        rd_mode = 1'b0;
        rd_addr = '0;
        rd_size = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 data", rsp_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk
        for (int i = 0; i < NVEC; i++) begin
            do_read(VECS[i].mode, VECS[i].addr, VECS[i].size, d, v);
            check("R2 valid", {31'd0, v}, 32'd1);
            check($sformatf("vector %0d (R3..R10)", i), d, VECS[i].exp);
        end

        // R2: valid drops and data holds while idle
        do_read(1'b0, 16'h0044, 2'd2, held, v);
        @(negedge clk);
        check("R2 valid low when idle", {31'd0, rsp_valid}, 32'd0);
        rd_mode = 1'b1;
        rd_addr = 16'h0000;
        repeat (2) @(negedge clk);
        check("R2 data held", rsp_data, held);
        check("R8 held value", held, 32'h59595252);

        // R1: reset after a read clears the output
        do_read(1'b1, 16'h0000, 2'd2, d, v);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", {31'd0, rsp_valid}, 32'd0);
        check("R1 data after reset", rsp_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: index 0x52 (first past the table) and wraparound index 0x151
        do_read(1'b0, 16'h0148, 2'd1, d, v);
        check("R4 index 0x52", d, 32'd0);
        do_read(1'b0, 16'h0544, 2'd1, d, v);
        check("R4 index 0x151", d, 32'd0);

        // R6: lanes equal in identifier mode too
        do_read(1'b1, 16'h0004, 2'd1, d, v);
        check("R6 id lanes", d, 32'h00001818);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule